// File: doc/BRIEF.md
# Six-Channel Synchronous Sampling Sequencer

This block runs an external 16-bit converter with six differential inputs. The inputs sit in three hold groups of two channels each. The block divides the system clock down to a conversion clock for the converter. When a sample-rate tick arrives, it pulls all three hold lines low at once, so every channel is captured at the same instant.

The converter is kept in a cyclic readout mode that carries no channel tag. After the end-of-conversion flag, the block issues exactly six read strobes and captures one word on each strobe's rising edge. It forwards each word downstream as a one-cycle valid pulse. The word's position in the burst is the only record of which channel it came from.

All control-line timing is counted in conversion-clock periods. The block is a single enumerated state machine with these states:
- `ST_IDLE`: waiting for a tick.
- `ST_HOLD`: the hold lines are low.
- `ST_WAIT`: waiting for end-of-conversion.
- `ST_RDLO`: the read strobe is low.
- `ST_RDHI`: the read strobe is high between reads.

The transitions, each taken on a conversion-clock step, are:
- `ST_IDLE`→`ST_HOLD` when a tick is pending and the block is enabled.
- `ST_HOLD`→`ST_WAIT` after one step.
- `ST_WAIT`→`ST_RDLO` when end-of-conversion is seen low.
- `ST_RDLO`→`ST_RDHI` after the strobe low time.
- `ST_RDHI`→`ST_RDLO` while channels remain.
- `ST_RDHI`→`ST_IDLE` after the sixth channel.

Top module: `adc_cycle_seq`

## Requirements
- R1: `adc_clk` has a period of DIV system clocks (default 10) and is high for DIV/2 of them. The state machine advances only on the system-clock edge where `adc_clk` is about to rise.
- R2: While `rst_n` is low, `hold_n`=3'b111, `cs_n`=1, `rd_n`=1, `out_valid`=0 and `overrun`=0. After reset, the next conversion's first word is channel 0 and it yields exactly six words.
- R3: A conversion starts only after a `rate_tick` seen while idle and enabled. Several ticks seen during one idle wait give a single conversion. All three `hold_n` lines fall together and stay low for one conversion-clock period.
- R4: `addr` is held at the cyclic-readout code MODE_ADDR (default 3'b110) at all times, including reset.
- R5: After the hold pulse, the block waits for `eoc_n` to be low on a conversion step. It then issues exactly NUM_CH (6) read strobes and no more until the next conversion.
- R6: `rd_n` stays low for RD_LOW (default 1) conversion-clock periods. The data bus is captured on the edge where `rd_n` rises, and `out_valid` is high for exactly the one system cycle after that edge.
- R7: Within a conversion, word k (k = 0..5) carries channel k. Channels come out in ascending order.
- R8: `cs_n` is low only during the read phase. It is low whenever `rd_n` is low, and it is high while any `hold_n` line is low and while idle.
- R9: A `rate_tick` seen while a conversion or readout is in progress sets the sticky `overrun` output and starts nothing. Only reset clears `overrun`.
- R10: While `en` is low, `rate_tick` has no effect: no hold pulse, no words and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allows ticks to start conversions |
| rate_tick | input | 1 | One-cycle sample-rate pulse |
| adc_clk | output | 1 | Divided conversion clock to the converter |
| hold_n | output | 3 | Active-low hold lines, one per channel pair |
| cs_n | output | 1 | Active-low chip select, low only for bus reads |
| rd_n | output | 1 | Active-low read strobe |
| addr | output | 3 | Address/mode lines held at the cyclic-readout code |
| eoc_n | input | 1 | Active-low end-of-conversion from the converter |
| adc_data | input | 16 | Converter parallel data bus |
| out_valid | output | 1 | One-cycle pulse per captured word |
| out_data | output | 16 | Captured word |
| overrun | output | 1 | Sticky flag: a tick arrived while busy |

## Verification
Some rules are checked by assertions on every cycle:
- the read strobe never runs without chip select;
- the overrun flag never drops;
- every `rd_n` rise is followed by exactly one valid pulse;
- a hold pulse always follows a pending tick;
- the divider rises right after each conversion step.

Other behaviour only the bench's directed scenarios can show. These are the ascending channel order, the exact count of six words, the merging of repeated idle ticks, ticks ignored while disabled, and the restart from channel 0 after a reset in mid-burst. An external converter model answers the strobes for these scenarios.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HOLD = 3'd1,
        ST_WAIT = 3'd2,
        ST_RDLO = 3'd3,
        ST_RDHI = 3'd4
    } seq_state_t;

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic adc_clk,
    output logic step
);
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          clk_q;

    always_comb begin
        if (cnt_q == CW'(DIV - 1)) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            clk_q <= (cnt_nxt < CW'(HALF));
        end
    end

    assign step    = (cnt_q == CW'(DIV - 1));
    assign adc_clk = clk_q;

    // R1
    step_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> adc_clk);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int GROUPS = 3,
    parameter int RD_LOW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              en,
    input  logic              rate_tick,
    input  logic              eoc_n,
    output logic [GROUPS-1:0] hold_n,
    output logic              cs_n,
    output logic              rd_n,
    output logic              capture,
    output logic              overrun
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int LO_W = (RD_LOW > 1) ? $clog2(RD_LOW) : 1;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
    localparam logic [LO_W-1:0] LAST_LO = LO_W'(RD_LOW - 1);

    seq_state_t      state_q;
    seq_state_t      state_nxt;
    logic [CH_W-1:0] ch_q;
    logic [LO_W-1:0] lo_q;
    logic            pend_q;
    logic            ovr_q;
    logic            cs_q;
    logic            rd_q;

    // next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (step && pend_q && en)          state_nxt = ST_HOLD;
            ST_HOLD: if (step)                          state_nxt = ST_WAIT;
            ST_WAIT: if (step && !eoc_n)                state_nxt = ST_RDLO;
            ST_RDLO: if (step && lo_q == LAST_LO)       state_nxt = ST_RDHI;
            ST_RDHI: if (step) state_nxt = (ch_q == LAST_CH) ? ST_IDLE : ST_RDLO;
            default:                                    state_nxt = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            lo_q    <= '0;
            pend_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (state_q == ST_RDLO && step) begin
                lo_q <= (lo_q == LAST_LO) ? '0 : lo_q + 1'b1;
            end
            if (state_q == ST_RDHI && step) begin
                ch_q <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
            end
            if (rate_tick && en && state_q != ST_IDLE) begin
                ovr_q <= 1'b1;
            end
            if (!en || (state_q == ST_IDLE && state_nxt != ST_IDLE)) begin
                pend_q <= 1'b0;
            end else if (rate_tick && state_q == ST_IDLE) begin
                pend_q <= 1'b1;
            end
        end
    end

    // registered outputs, derived from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            cs_q <= !(state_nxt == ST_RDLO || state_nxt == ST_RDHI);
            rd_q <= (state_nxt != ST_RDLO);
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_hold
        logic hq;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hq <= 1'b1;
            end else begin
                hq <= (state_nxt != ST_HOLD);
            end
        end
        assign hold_n[g] = hq;
    end

    assign cs_n    = cs_q;
    assign rd_n    = rd_q;
    assign overrun = ovr_q;
    assign capture = (state_q == ST_RDLO) && (state_nxt == ST_RDHI);

    // R3
    hold_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_n[0]) |-> $past(pend_q));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R5
    read_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDLO && $past(state_q) != ST_RDLO)
            |-> ($past(state_q) == ST_WAIT || $past(state_q) == ST_RDHI));

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] adc_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic          vld_q;
    logic [DW-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= capture;
            if (capture) begin
                dat_q <= adc_data;
            end
        end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

endmodule

// File: rtl/adc_cycle_seq.sv
module adc_cycle_seq #(
    parameter int          DIV       = 10,
    parameter int          NUM_CH    = 6,
    parameter int          GROUPS    = 3,
    parameter int          DW        = 16,
    parameter int          RD_LOW    = 1,
    parameter int          ADDR_W    = 3,
    parameter logic [2:0]  MODE_ADDR = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rate_tick,
    output logic              adc_clk,
    output logic [GROUPS-1:0] hold_n,
    output logic              cs_n,
    output logic              rd_n,
    output logic [ADDR_W-1:0] addr,
    input  logic              eoc_n,
    input  logic [DW-1:0]     adc_data,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    output logic              overrun
);
    logic step;
    logic capture;

    adc_seq_clkdiv #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .adc_clk (adc_clk),
        .step    (step)
    );

    adc_seq_fsm #(
        .NUM_CH (NUM_CH),
        .GROUPS (GROUPS),
        .RD_LOW (RD_LOW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .en        (en),
        .rate_tick (rate_tick),
        .eoc_n     (eoc_n),
        .hold_n    (hold_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .capture   (capture),
        .overrun   (overrun)
    );

    adc_seq_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .adc_data  (adc_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign addr = ADDR_W'(MODE_ADDR);

    // R8
    rd_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    // R6
    rd_rise_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> out_valid);

endmodule

// File: tb/sim_adc_cycle_seq.sv
module sim_adc_cycle_seq;
    localparam int CLK_PERIOD = 20;
    localparam int EOC_DLY    = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        rate_tick = 1'b0;
    logic        adc_clk;
    logic [2:0]  hold_n;
    logic        cs_n;
    logic        rd_n;
    logic [2:0]  addr;
    logic        eoc_n = 1'b0;
    logic [15:0] adc_data = 16'h0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        overrun;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int holds = 0;
    int wcount = 0;
    int hold_bad = 0;
    int cs_bad = 0;
    int addr_bad = 0;
    int m_ch = 0;
    int eoc_cnt = 0;
    logic prev_hold = 1'b1;
    logic prev_rd = 1'b1;
    logic [15:0] words [0:63];

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_cycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .rate_tick(rate_tick),
        .adc_clk(adc_clk), .hold_n(hold_n), .cs_n(cs_n), .rd_n(rd_n),
        .addr(addr), .eoc_n(eoc_n), .adc_data(adc_data),
        .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    // converter model and monitors, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (hold_n != 3'b000 && hold_n != 3'b111) hold_bad++;
        if (!rd_n && cs_n) cs_bad++;
        if (hold_n != 3'b111 && !cs_n) cs_bad++;
        if (addr != 3'b110) addr_bad++;
        if (prev_hold && !hold_n[0]) begin
            holds++;
            m_ch = 0;
        end
        if (!hold_n[0]) begin
            eoc_n = 1'b1;
            eoc_cnt = EOC_DLY;
        end else if (eoc_cnt > 0) begin
            eoc_cnt--;
        end else begin
            eoc_n = 1'b0;
        end
        if (prev_rd && !rd_n) begin
            adc_data = {4'hC, 8'(holds), 4'(m_ch)};
            m_ch++;
        end
        if (out_valid) begin
            if (wcount < 64) words[wcount] = out_data;
            wcount++;
        end
        prev_hold = hold_n[0];
        prev_rd = rd_n;
    end

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        rate_tick = 1'b1;
        @(negedge clk);
        rate_tick = 1'b0;
    endtask

    task automatic check_burst(input int base_w, input int base_h, input string req);
        chk(holds == base_h + 1, {req, " one hold pulse"}, holds, base_h + 1);
        chk(wcount == base_w + 6, {req, " six words"}, wcount, base_w + 6);
        for (int k = 0; k < 6; k++) begin
            if (base_w + k < 64)
                chk(words[base_w + k] == {4'hC, 8'(base_h + 1), 4'(k)},
                    {req, " R7 channel order"}, int'(words[base_w + k]),
                    int'({4'hC, 8'(base_h + 1), 4'(k)}));
        end
    endtask

    // R2: reset state
    task automatic t_reset_state();
        @(negedge clk);
        chk(hold_n == 3'b111, "R2 hold_n", hold_n, 3'b111);
        chk(cs_n && rd_n, "R2 cs_n/rd_n", {cs_n, rd_n}, 2'b11);
        chk(!out_valid, "R2 out_valid", out_valid, 0);
        chk(!overrun, "R2 overrun", overrun, 0);
        chk(addr == 3'b110, "R4 addr in reset", addr, 3'b110);
    endtask

    // R1: divider period and duty
    task automatic t_divider();
        int hi = 0;
        int per = 0;
        while (adc_clk !== 1'b0) @(negedge clk);
        while (adc_clk !== 1'b1) @(negedge clk);
        while (adc_clk === 1'b1) begin hi++; @(negedge clk); end
        per = hi;
        while (adc_clk === 1'b0) begin per++; @(negedge clk); end
        chk(hi == 5, "R1 high time", hi, 5);
        chk(per == 10, "R1 period", per, 10);
    endtask

    // R3 R5 R6 R7: one normal conversion
    task automatic t_single(input string req);
        int bw = wcount;
        int bh = holds;
        pulse_tick();
        repeat (400) @(negedge clk);
        check_burst(bw, bh, req);
    endtask

    // R3: several ticks within one idle wait give one conversion
    task automatic t_double_tick();
        int bw = wcount;
        int bh = holds;
        while (adc_clk !== 1'b0) @(negedge clk);
        while (adc_clk !== 1'b1) @(negedge clk);
        rate_tick = 1'b1;
        @(negedge clk);
        rate_tick = 1'b0;
        @(negedge clk);
        rate_tick = 1'b1;
        @(negedge clk);
        rate_tick = 1'b0;
        repeat (400) @(negedge clk);
        check_burst(bw, bh, "R3 merged ticks");
        chk(!overrun, "R9 no overrun from idle ticks", overrun, 0);
    endtask

    // R10: ticks ignored while disabled
    task automatic t_disabled();
        int bw = wcount;
        int bh = holds;
        en = 1'b0;
        pulse_tick();
        repeat (400) @(negedge clk);
        chk(holds == bh, "R10 no hold", holds, bh);
        chk(wcount == bw, "R10 no words", wcount, bw);
        chk(!overrun, "R10 no overrun", overrun, 0);
        en = 1'b1;
    endtask

    // R9: tick during readout
    task automatic t_overrun();
        int bw = wcount;
        int bh = holds;
        pulse_tick();
        while (wcount < bw + 2) @(negedge clk);
        pulse_tick();
        repeat (400) @(negedge clk);
        chk(overrun, "R9 overrun set", overrun, 1);
        check_burst(bw, bh, "R9 busy tick ignored");
        t_single("R9 sticky");
        chk(overrun, "R9 overrun still set", overrun, 1);
    endtask

    // R2: reset in the middle of a burst
    task automatic t_mid_reset();
        int bw = wcount;
        pulse_tick();
        while (wcount < bw + 3) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        t_single("R2 restart from channel 0");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        en = 1'b1;
        t_divider();
        t_single("R5 first conversion");
        t_double_tick();
        t_disabled();
        t_overrun();
        t_mid_reset();
        chk(hold_bad == 0, "R3 hold lines together", hold_bad, 0);
        chk(cs_bad == 0, "R8 cs_n only during reads", cs_bad, 0);
        chk(addr_bad == 0, "R4 addr constant", addr_bad, 0);
        summary_and_end();
    end

endmodule